// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block watches the clock and data wires of a two-wire serial bus and reports conditions at the bus level. Both wires pass through a two-stage synchronizer. The synchronized samples are then compared with the samples from the previous clock. From that comparison the block finds START and STOP conditions and keeps a bus-busy indication.

A START or STOP that appears while the protocol engine says a bit of a frame is in progress is reported as a bus error. The frame bits in question are address, data or acknowledge bits.

Two further checks look for a stuck bus:

- **Hang detector.** A small counter advances on sample ticks while the clock wire stays high. If the counter wraps while the data wire is low, the hang flag is raised.
- **Timeout.** A programmable timeout counts timeout ticks from the last time software cleared any event flag.

Four event flags are sticky and are cleared by writing one: START, STOP, bus error and timeout. Each flag has its own enable into a single interrupt output. The hang indication is a plain status bit and never raises the interrupt.

Top module: `i2c_bus_watch`

## Requirements
- R1: A START is the synchronized data wire falling while the synchronized clock wire is high on both the current and the previous sample. It sets event flag bit 0. A STOP is the data wire rising under the same clock condition and sets event flag bit 1.
- R2: `bus_busy` becomes 1 after a START and returns to 0 after a STOP.
- R3: A START or STOP that occurs while `in_frame` is 1 sets event flag bit 2 (bus error). When `in_frame` is 0 the same conditions leave bit 2 at 0.
- R4: The 4-bit hang counter advances on each `samp_tick` cycle while the clock wire is high. Every falling edge of the clock wire resets it to zero.
- R5: `bus_hang` becomes 1 on the sixteenth counted tick after the counter was last zeroed, provided the data wire is low. The counter wraps at that tick. If the data wire is high, the hang flag stays at 0.
- R6: `bus_hang` stays set through a STOP and is cleared by the next START. It never contributes to `irq`.
- R7: With `to_limit` equal to L and non-zero, event flag bit 3 (timeout) is set on the L-th `to_tick` after the last clear write. With `to_limit` equal to 0, the timeout never fires.
- R8: After it fires, the timeout stops counting. Any clear write with at least one bit set reloads the timeout count and rearms it, so the timeout fires again L ticks after that write.
- R9: Event flags stay set until cleared. A 1 in a bit of `flag_clr` clears only that flag.
- R10: `irq` is 1 exactly when some event flag is 1 and its matching bit of `irq_en` is 1.
- R11: After reset, the flags, `bus_busy`, `bus_hang` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw clock wire level |
| sda_in | input | 1 | Raw data wire level |
| samp_tick | input | 1 | Sample tick for the hang counter |
| in_frame | input | 1 | Protocol engine is inside an address, data or acknowledge bit |
| to_tick | input | 1 | Timeout counting tick |
| to_limit | input | 10 | Timeout length in ticks, 0 disables |
| irq_en | input | 4 | Per-flag interrupt enables (bit 0 START, 1 STOP, 2 bus error, 3 timeout) |
| flag_clr | input | 4 | Write-one-to-clear strobe, one bit per flag |
| evt_flags | output | 4 | Sticky event flags |
| bus_busy | output | 1 | Bus busy indication |
| bus_hang | output | 1 | Bus hang status |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check the following:

- `bus_busy` follows detected START and STOP conditions.
- The hang counter is zero after a clock-wire falling edge.
- A START clears the hang flag.
- Flags hold when neither set nor cleared.
- The timeout flag never rises while the limit is zero.

Only the bench scenarios can show the cases that need an exact tick count or depend on the frame context:

- the sixteenth-tick hang threshold and its dependence on the data-wire level;
- the L-tick timeout position for a sweep of limits;
- the rearm after a clear;
- the error classification by `in_frame`;
- the full interrupt-enable sweep.

// File: rtl/i2c_bus_watch_pkg.sv
package i2c_bus_watch_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int FLG_START = 0;
  localparam int FLG_STOP  = 1;
  localparam int FLG_BERR  = 2;
  localparam int FLG_TOUT  = 3;
endpackage

// File: rtl/bw_line_sync.sv
module bw_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      // Idle bus level is high on both wires.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/bw_cond_detect.sv
module bw_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_p,
  output logic stop_p,
  output logic scl_fall,
  output logic busy
);
  logic scl_q, sda_q, busy_q, busy_d;
  logic scl_stable_hi;

  always_comb begin
    scl_stable_hi = scl & scl_q;
    start_p  = scl_stable_hi & sda_q & ~sda;
    stop_p   = scl_stable_hi & ~sda_q & sda;
    scl_fall = scl_q & ~scl;
    busy_d   = busy_q;
    if (start_p)     busy_d = 1'b1;
    else if (stop_p) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_q  <= scl;
      sda_q  <= sda;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> busy); // R2
  AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !busy); // R2
  AST_NO_DUAL_COND: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_p && stop_p)); // R1
endmodule

// File: rtl/bw_hang_det.sv
module bw_hang_det #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic scl,
  input  logic sda,
  input  logic scl_fall,
  input  logic start_p,
  output logic hang
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic hang_q, hang_d, wrap;

  always_comb begin
    wrap   = tick & scl & ~scl_fall & (cnt_q == CNT_MAX);
    cnt_d  = cnt_q;
    if (scl_fall)         cnt_d = '0;
    else if (tick && scl) cnt_d = cnt_q + 1'b1;
    hang_d = hang_q;
    if (start_p)          hang_d = 1'b0;
    else if (wrap && !sda) hang_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hang_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hang_q <= hang_d;
    end
  end

  assign hang = hang_q;

  AST_CNT_ZERO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> (cnt_q == '0)); // R4
  AST_HANG_CLEARED_BY_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !hang); // R6
endmodule

// File: rtl/bw_timeout.sv
module bw_timeout #(
  parameter int TO_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rearm,
  input  logic [TO_W-1:0] limit,
  output logic            hit
);
  logic [TO_W-1:0] cnt_q, cnt_d;
  logic fired_q, fired_d, enabled, at_end;

  always_comb begin
    enabled = (limit != '0);
    at_end  = (cnt_q >= limit - 1'b1);
    hit     = tick & enabled & ~fired_q & ~rearm & at_end;
    cnt_d   = cnt_q;
    fired_d = fired_q;
    if (rearm) begin
      cnt_d   = '0;
      fired_d = 1'b0;
    end else if (tick && enabled && !fired_q) begin
      if (at_end) begin
        cnt_d   = '0;
        fired_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
    end
  end

  AST_TO_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> !hit); // R7
endmodule

// File: rtl/bw_flag_bank.sv
module bw_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flag_q, flag_d;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_flag
      always_comb flag_d[i] = set[i] | (flag_q[i] & ~clr[i]);

      AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[i] && !clr[i]) |=> flag_q[i]); // R9
      AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[i]) |-> $past(set[i])); // R9
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & en);
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
  import i2c_bus_watch_pkg::*;
#(
  parameter int TO_W   = 10,
  parameter int HANG_W = 4,
  parameter int SYNC_N = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_in,
  input  logic                 sda_in,
  input  logic                 samp_tick,
  input  logic                 in_frame,
  input  logic                 to_tick,
  input  logic [TO_W-1:0]      to_limit,
  input  logic [NUM_FLAGS-1:0] irq_en,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  output logic [NUM_FLAGS-1:0] evt_flags,
  output logic                 bus_busy,
  output logic                 bus_hang,
  output logic                 irq
);
  logic [1:0] line_s;
  logic scl_s, sda_s;
  logic start_p, stop_p, scl_fall, to_hit, rearm;
  logic [NUM_FLAGS-1:0] flag_set;

  bw_line_sync #(.WIDTH(2), .STAGES(SYNC_N)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s));

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  bw_cond_detect i_cond (
    .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
    .start_p(start_p), .stop_p(stop_p), .scl_fall(scl_fall), .busy(bus_busy));

  bw_hang_det #(.CNT_W(HANG_W)) i_hang (
    .clk(clk), .rst_n(rst_n), .tick(samp_tick), .scl(scl_s), .sda(sda_s),
    .scl_fall(scl_fall), .start_p(start_p), .hang(bus_hang));

  assign rearm = |flag_clr;

  bw_timeout #(.TO_W(TO_W)) i_tout (
    .clk(clk), .rst_n(rst_n), .tick(to_tick), .rearm(rearm),
    .limit(to_limit), .hit(to_hit));

  always_comb begin
    flag_set            = '0;
    flag_set[FLG_START] = start_p;
    flag_set[FLG_STOP]  = stop_p;
    flag_set[FLG_BERR]  = (start_p | stop_p) & in_frame;
    flag_set[FLG_TOUT]  = to_hit;
  end

  bw_flag_bank #(.N(NUM_FLAGS)) i_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr),
    .en(irq_en), .flags(evt_flags), .irq(irq));

  AST_TOUT_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flags[FLG_TOUT]) |-> ($past(to_limit) != '0)); // R7
  AST_BERR_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flags[FLG_BERR]) |-> $past(in_frame)); // R3
  AST_START_FLAG_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> evt_flags[FLG_START]); // R1
endmodule

// File: tb/test_i2c_bus_watch.sv
module test_i2c_bus_watch;
  logic clk = 1'b0;
  logic rst_n;
  logic scl_in, sda_in, samp_tick, in_frame, to_tick;
  logic [9:0] to_limit;
  logic [3:0] irq_en, flag_clr;
  logic [3:0] evt_flags;
  logic bus_busy, bus_hang, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_bus_watch i_i2c_bus_watch (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .samp_tick(samp_tick), .in_frame(in_frame), .to_tick(to_tick),
    .to_limit(to_limit), .irq_en(irq_en), .flag_clr(flag_clr),
    .evt_flags(evt_flags), .bus_busy(bus_busy), .bus_hang(bus_hang), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lines(input logic c, input logic d);
    @(negedge clk);
    scl_in = c;
    sda_in = d;
    cyc(5);
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk);
    flag_clr = m;
    @(negedge clk);
    flag_clr = 4'h0;
  endtask

  task automatic stick();
    samp_tick = 1'b1;
    @(negedge clk);
    samp_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ttick();
    to_tick = 1'b1;
    @(negedge clk);
    to_tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    cyc(20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    scl_in = 1'b1; sda_in = 1'b1; samp_tick = 1'b0; in_frame = 1'b0;
    to_tick = 1'b0; to_limit = '0; irq_en = 4'h0; flag_clr = 4'h0;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    // R11 reset state
    chk(evt_flags == 4'h0 && !bus_busy && !bus_hang && !irq, "R11",
        {evt_flags, bus_busy, bus_hang, irq}, 0);

    // R1 R2 R3: START and STOP outside a frame
    lines(1, 0);
    chk(evt_flags == 4'b0001, "R1 start", evt_flags, 4'b0001);
    chk(bus_busy, "R2 busy set", bus_busy, 1);
    lines(1, 1);
    chk(evt_flags == 4'b0011, "R1 stop/R3 no error", evt_flags, 4'b0011);
    chk(!bus_busy, "R2 busy clear", bus_busy, 0);

    // R9 selective clear
    clear(4'b0001);
    chk(evt_flags == 4'b0010, "R9 selective clear", evt_flags, 4'b0010);
    clear(4'hF);
    chk(evt_flags == 4'h0, "R9 clear all", evt_flags, 0);

    // R3 inside a frame
    in_frame = 1'b1;
    lines(1, 0);
    chk(evt_flags == 4'b0101, "R3 start in frame", evt_flags, 4'b0101);
    lines(1, 1);
    chk(evt_flags == 4'b0111, "R3 stop in frame", evt_flags, 4'b0111);
    in_frame = 1'b0;
    clear(4'hF);

    // R4 R5 hang detection with data low
    lines(1, 0);
    lines(0, 0);
    lines(1, 0);
    for (int k = 0; k < 10; k++) stick();
    lines(0, 0);
    lines(1, 0);
    for (int k = 1; k <= 16; k++) begin
      stick();
      chk(bus_hang == (k == 16), "R4/R5 hang threshold", bus_hang, (k == 16));
    end
    clear(4'hF);
    irq_en = 4'hF;
    cyc(2);
    chk(!irq, "R6 hang raises no irq", irq, 0);
    irq_en = 4'h0;
    lines(1, 1);
    chk(bus_hang, "R6 hang held through STOP", bus_hang, 1);
    lines(1, 0);
    chk(!bus_hang, "R6 START clears hang", bus_hang, 0);

    // R5 data high: no hang
    lines(0, 0);
    lines(0, 1);
    lines(1, 1);
    for (int k = 0; k < 20; k++) stick();
    chk(!bus_hang, "R5 no hang with data high", bus_hang, 0);
    lines(0, 1);
    lines(1, 1);
    clear(4'hF);

    // R7 R8 timeout sweep
    for (int L = 1; L <= 6; L++) begin
      to_limit = 10'(L);
      clear(4'hF);
      for (int k = 1; k < L; k++) ttick();
      chk(!evt_flags[3], "R7 timeout early", evt_flags[3], 0);
      ttick();
      chk(evt_flags[3], "R7 timeout at limit", evt_flags[3], 1);
      ttick();
      ttick();
      chk(evt_flags[3], "R9 timeout sticky", evt_flags[3], 1);
      clear(4'b1000);
      for (int k = 1; k < L; k++) ttick();
      chk(!evt_flags[3], "R8 rearm early", evt_flags[3], 0);
      ttick();
      chk(evt_flags[3], "R8 rearm fires", evt_flags[3], 1);
    end
    to_limit = '0;
    clear(4'hF);
    for (int k = 0; k < 20; k++) ttick();
    chk(!evt_flags[3], "R7 zero limit disables", evt_flags[3], 0);

    // R10 interrupt enable sweep
    in_frame = 1'b1;
    lines(1, 0);
    lines(1, 1);
    in_frame = 1'b0;
    to_limit = 10'd1;
    clear(4'h0);
    ttick();
    to_limit = '0;
    chk(evt_flags == 4'hF, "R10 setup all flags", evt_flags, 4'hF);
    for (int e = 0; e < 16; e++) begin
      irq_en = 4'(e);
      cyc(1);
      chk(irq == (e != 0), "R10 irq all flags", irq, (e != 0));
    end
    clear(4'b0101);
    for (int e = 0; e < 16; e++) begin
      irq_en = 4'(e);
      cyc(1);
      chk(irq == ((e & 4'b1010) != 0), "R10 irq partial", irq, ((e & 4'b1010) != 0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule